// File: doc/BRIEF.md
# Unit First/Next Error Logger

This block records the error events raised inside one functional unit. Each cycle it takes a vector of single-cycle error pulses. While its first-error register is empty, every pulse that arrives is latched there. The register then locks, and any later error is added to a sticky next-error register. This gives software the exact error type that occurred first, and every type that followed, for this one unit.

A parameter mask marks each error bit as fatal or non-fatal. From that mask, and from both registers, the block drives two level summaries toward a chip-level error aggregator. Software reads either register through a small register port and clears bits by writing ones to them.

Top module: `unit_err_logger`

## Requirements
- R1: After reset both registers read zero and both severity outputs are low.
- R2: When the first-error register is zero, all error bits that pulse in a cycle (one or several) are latched into it on the next clock, and the next-error register does not change.
- R3: While the first-error register is non-zero, new errors do not change it. They are ORed into the next-error register instead.
- R4: Next-error bits are sticky. They accumulate until software clears them.
- R5: A write with reg_addr=0 clears each first-error bit whose reg_wdata bit is 1. A write with reg_addr=1 does the same for the next-error register. Bits written as 0 keep their value. The cleared value is visible after the clock edge that takes the write.
- R6: An error pulse is never lost. If it arrives in the same cycle as a write that clears its bit, the error still ends up set in one of the two registers.
- R7: The lock decision uses the first-error value left after that cycle's clear. If software clears the whole register, an error in that same cycle or in any later cycle is captured there again.
- R8: sev_fatal is high while any bit selected by FATAL_MASK (default 8'hF0, bits 7..4) is set in either register. sev_nonfatal is high while any unselected bit is set in either register.
- R9: reg_rdata shows the first-error register when reg_addr=0 and the next-error register when reg_addr=1, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_in | input | N_ERR | Single-cycle error pulses, one bit per error type |
| reg_wr | input | 1 | Write strobe for write-one-to-clear |
| reg_addr | input | 1 | Register select: 0 first-error, 1 next-error |
| reg_wdata | input | N_ERR | Mask of bits to clear |
| reg_rdata | output | N_ERR | Read data of the selected register |
| sev_fatal | output | 1 | Level: a fatal-class error is recorded |
| sev_nonfatal | output | 1 | Level: a non-fatal-class error is recorded |

## Verification
The bench raises several errors in one cycle while the first-error register is empty. A design that latched only one bit, or that split the bits across the two registers, fails this test. It then collides a clear with an error on the same bit. A design that gave the clear priority would drop that event. It also clears the first-error register in the same cycle as a new error. A design that locked on the stale pre-clear value would file that error as a next error. Finally, it clears only the fatal bits and checks that the fatal summary falls while the non-fatal summary stays up. This catches summaries that are computed from one register only or that use the wrong mask.

// File: rtl/uel_pkg.sv
package uel_pkg;
    typedef enum logic {
        SEL_FIRST = 1'b0,
        SEL_NEXT  = 1'b1
    } uel_sel_e;
endpackage

// File: rtl/uel_clear_decode.sv
module uel_clear_decode #(
    parameter int N_ERR = 8
) (
    input  logic             reg_wr,
    input  logic             reg_addr,
    input  logic [N_ERR-1:0] reg_wdata,
    output logic [N_ERR-1:0] clr_first,
    output logic [N_ERR-1:0] clr_next
);
    import uel_pkg::*;

    always_comb begin
        clr_first = '0;
        clr_next  = '0;
        if (reg_wr) begin
            if (uel_sel_e'(reg_addr) == SEL_FIRST) clr_first = reg_wdata;
            else                                   clr_next  = reg_wdata;
        end
    end
endmodule

// File: rtl/uel_capture.sv
module uel_capture #(
    parameter int N_ERR = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_ERR-1:0] err_in,
    input  logic [N_ERR-1:0] clr_first,
    input  logic [N_ERR-1:0] clr_next,
    output logic [N_ERR-1:0] first_q,
    output logic [N_ERR-1:0] next_q
);
    typedef struct packed {
        logic [N_ERR-1:0] first;
        logic [N_ERR-1:0] next;
    } cap_state_t;

    cap_state_t st_d, st_q;
    logic [N_ERR-1:0] first_kept;
    logic [N_ERR-1:0] next_kept;
    logic             locked;

    always_comb begin
        first_kept = st_q.first & ~clr_first;
        next_kept  = st_q.next  & ~clr_next;
        locked     = |first_kept;
        st_d.first = first_kept;
        st_d.next  = next_kept;
        if (locked) st_d.next  = next_kept | err_in;
        else        st_d.first = err_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign first_q = st_q.first;
    assign next_q  = st_q.next;
endmodule

// File: rtl/uel_severity.sv
module uel_severity #(
    parameter int               N_ERR      = 8,
    parameter logic [N_ERR-1:0] FATAL_MASK = 8'hF0
) (
    input  logic [N_ERR-1:0] first_q,
    input  logic [N_ERR-1:0] next_q,
    output logic             sev_fatal,
    output logic             sev_nonfatal
);
    logic [N_ERR-1:0] seen;

    always_comb begin
        seen         = first_q | next_q;
        sev_fatal    = |(seen & FATAL_MASK);
        sev_nonfatal = |(seen & ~FATAL_MASK);
    end
endmodule

// File: rtl/unit_err_logger.sv
module unit_err_logger #(
    parameter int               N_ERR      = 8,
    parameter logic [N_ERR-1:0] FATAL_MASK = 8'hF0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_ERR-1:0] err_in,
    input  logic             reg_wr,
    input  logic             reg_addr,
    input  logic [N_ERR-1:0] reg_wdata,
    output logic [N_ERR-1:0] reg_rdata,
    output logic             sev_fatal,
    output logic             sev_nonfatal
);
    import uel_pkg::*;

    logic [N_ERR-1:0] clr_first;
    logic [N_ERR-1:0] clr_next;
    logic [N_ERR-1:0] first_q;
    logic [N_ERR-1:0] next_q;

    uel_clear_decode #(.N_ERR(N_ERR)) u_dec (
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .clr_first (clr_first),
        .clr_next  (clr_next)
    );

    uel_capture #(.N_ERR(N_ERR)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .err_in    (err_in),
        .clr_first (clr_first),
        .clr_next  (clr_next),
        .first_q   (first_q),
        .next_q    (next_q)
    );

    uel_severity #(.N_ERR(N_ERR), .FATAL_MASK(FATAL_MASK)) u_sev (
        .first_q      (first_q),
        .next_q       (next_q),
        .sev_fatal    (sev_fatal),
        .sev_nonfatal (sev_nonfatal)
    );

    assign reg_rdata = (uel_sel_e'(reg_addr) == SEL_FIRST) ? first_q : next_q;
endmodule

// File: rtl/uel_checker.sv
module uel_checker #(
    parameter int N_ERR = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_ERR-1:0] err_in,
    input logic             reg_wr,
    input logic             reg_addr,
    input logic [N_ERR-1:0] first_q,
    input logic [N_ERR-1:0] next_q,
    input logic             sev_fatal,
    input logic             sev_nonfatal
);
    AST_CAPTURE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (first_q == '0 && err_in != '0) |=> (first_q == $past(err_in))); // R2

    AST_FIRST_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (first_q != '0 && !(reg_wr && reg_addr == 1'b0)) |=> (first_q == $past(first_q))); // R3

    AST_NEXT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == 1'b1) |=> ((next_q & $past(next_q)) == $past(next_q))); // R4

    AST_NO_LOST_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (err_in != '0) |=> (((first_q | next_q) & $past(err_in)) == $past(err_in))); // R6

    AST_SEV_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (sev_fatal || sev_nonfatal) |-> ((first_q | next_q) != '0)); // R8
endmodule

bind unit_err_logger uel_checker #(.N_ERR(N_ERR)) u_uel_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .err_in       (err_in),
    .reg_wr       (reg_wr),
    .reg_addr     (reg_addr),
    .first_q      (first_q),
    .next_q       (next_q),
    .sev_fatal    (sev_fatal),
    .sev_nonfatal (sev_nonfatal)
);

// File: tb/unit_err_logger_bench.sv
`timescale 1ns/1ps
module unit_err_logger_bench;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] err_in = '0;
    logic         reg_wr = 1'b0;
    logic         reg_addr = 1'b0;
    logic [W-1:0] reg_wdata = '0;
    logic [W-1:0] reg_rdata;
    logic         sev_fatal;
    logic         sev_nonfatal;

    int n_checks = 0;
    int n_errors = 0;

    always #2 clk = ~clk;

    unit_err_logger #(.N_ERR(W), .FATAL_MASK(8'hF0)) u_unit_err_logger (
        .clk, .rst_n, .err_in, .reg_wr, .reg_addr, .reg_wdata,
        .reg_rdata, .sev_fatal, .sev_nonfatal
    );

    task automatic chk(input string req, input string what, input logic [W-1:0] got, input logic [W-1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    // one cycle of stimulus, driven at negedge; state sampled at the following negedge
    task automatic step(input logic [W-1:0] err, input logic wr, input logic addr, input logic [W-1:0] data);
        @(negedge clk);
        err_in = err; reg_wr = wr; reg_addr = addr; reg_wdata = data;
        @(negedge clk);
        err_in = '0; reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic expect_regs(input string req, input logic [W-1:0] f, input logic [W-1:0] n);
        reg_addr = 1'b0; #0.5;
        chk(req, "first", reg_rdata, f);
        reg_addr = 1'b1; #0.5;
        chk(req, "next", reg_rdata, n);
    endtask

    task automatic expect_sev(input string req, input logic fat, input logic nf);
        chk(req, "sev_fatal", {7'd0, sev_fatal}, {7'd0, fat});
        chk(req, "sev_nonfatal", {7'd0, sev_nonfatal}, {7'd0, nf});
    endtask

    task automatic t_reset;
        expect_regs("R1", 8'h00, 8'h00);
        expect_sev("R1", 1'b0, 1'b0);
    endtask

    task automatic t_capture;
        step(8'h05, 1'b0, 1'b0, 8'h00);
        expect_regs("R2", 8'h05, 8'h00);      // two bits in one cycle
        expect_sev("R8", 1'b0, 1'b1);
    endtask

    task automatic t_lock;
        step(8'h40, 1'b0, 1'b0, 8'h00);
        expect_regs("R3", 8'h05, 8'h40);
        expect_sev("R8", 1'b1, 1'b1);
        step(8'h01, 1'b0, 1'b0, 8'h00);
        expect_regs("R4", 8'h05, 8'h41);
    endtask

    task automatic t_clear;
        step(8'h00, 1'b1, 1'b0, 8'h00);       // zero mask: no effect
        expect_regs("R5", 8'h05, 8'h41);
        step(8'h00, 1'b1, 1'b1, 8'h40);
        expect_regs("R5", 8'h05, 8'h01);
        expect_sev("R8", 1'b0, 1'b1);         // fatal falls, non-fatal stays
        step(8'h00, 1'b1, 1'b0, 8'h05);
        expect_regs("R5", 8'h00, 8'h01);
        step(8'h20, 1'b0, 1'b0, 8'h00);
        expect_regs("R7", 8'h20, 8'h01);
    endtask

    task automatic t_collide;
        step(8'h01, 1'b1, 1'b1, 8'h01);       // clear NERR bit0 while bit0 errors again
        expect_regs("R6", 8'h20, 8'h01);
        step(8'h08, 1'b1, 1'b0, 8'h20);       // empty FERR and new error in same cycle
        expect_regs("R7", 8'h08, 8'h01);
        step(8'h00, 1'b1, 1'b1, 8'h01);
        step(8'h00, 1'b1, 1'b0, 8'h08);
        expect_regs("R5", 8'h00, 8'h00);
        expect_sev("R8", 1'b0, 1'b0);
    endtask

    task automatic t_read;
        step(8'h80, 1'b0, 1'b0, 8'h00);
        step(8'h02, 1'b0, 1'b0, 8'h00);
        reg_addr = 1'b1; #0.5;
        chk("R9", "rdata next", reg_rdata, 8'h02);
        reg_addr = 1'b0; #0.5;
        chk("R9", "rdata first", reg_rdata, 8'h80);
        expect_sev("R8", 1'b1, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        t_capture;
        t_lock;
        t_clear;
        t_collide;
        t_read;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule